// File: doc/BRIEF.md
# Address Translation Unit with LRU TLB and Page-Table Fallback

This block turns a virtual address into a 40-bit physical address using 4 KiB pages. A four-entry, fully associative translation cache answers most requests in one cycle. When the cache has no matching entry, the block reads a page table held in on-chip registers. If that page is resident, it refills the least recently used cache slot and answers one cycle later. If the page is not resident, it reports a page fault. It does not handle the fault itself.

Each request carries an access kind: instruction fetch, data read or data write. Writes mark the page dirty. The dirty state lives in the cache entry and is copied back to the page table when that entry is evicted. The page table is filled through a separate load port, which a test or a supervisor uses before traffic starts.

Top module: `xl_tlb`

## Requirements
- R1: The physical address is `{ppn, vaddr[11:0]}`: the 12 offset bits pass through unchanged and a 28-bit page number sits above them, 40 bits in all. The virtual page number is `vaddr[19:12]`.
- R2: `req_kind` codes are 0 = fetch, 1 = read, 2 = write, 3 = read. A write leaves the page dirty. A fetch or read never sets dirty. `resp_dirty` gives the page's dirty state after the access.
- R3: If the page is held in the cache, the response comes in the cycle after acceptance with `resp_miss`=0 and `resp_fault`=0.
- R4: A cache miss drops `req_ready` for one cycle, during which requests are ignored. The response comes two cycles after acceptance with `resp_miss`=1. A resident page is then held in the cache.
- R5: A refill replaces the least recently used of the four slots. Every hit or refill makes its slot the most recently used.
- R6: An access to a non-resident page gives `resp_fault`=1 and `resp_miss`=1, with `resp_paddr`=0 and `resp_dirty`=0. Neither the cache contents nor the recency order change.
- R7: Evicting a dirty cache entry sets the dirty bit of that page in the page table. A later refill of that page reports it dirty.
- R8: A refilled entry's dirty bit is the page-table dirty bit OR (access is a write).
- R9: A load-port write sets the resident bit, dirty bit and page number of one table entry from the next cycle on. It does not alter entries already in the cache.
- R10: After reset, `req_ready`=1, `resp_valid`=0, the cache is empty and every page-table entry is non-resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_vaddr | input | 20 | Virtual address |
| req_kind | input | 2 | Access kind code |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response present |
| resp_paddr | output | 40 | Physical address |
| resp_miss | output | 1 | Access missed in the cache |
| resp_fault | output | 1 | Page not resident |
| resp_dirty | output | 1 | Page dirty after the access |
| pt_ld_en | input | 1 | Page-table load strobe |
| pt_ld_vpn | input | 8 | Page-table entry to load |
| pt_ld_resident | input | 1 | Resident bit to load |
| pt_ld_dirty | input | 1 | Dirty bit to load |
| pt_ld_ppn | input | 28 | Physical page number to load |

## Verification
The hardest case to reach is a dirty write-back. Some page must be written while cached, and then aged out by four newer refills without being touched again. Only a later miss on that page shows the write-back, through `resp_dirty`. The stimulus does this on purpose: it writes a page, walks through four other resident pages, and then reads the first page again. It also reloads a cached page's table entry to show the stale cached translation is still served, and it inserts faults between hits to show the recency order is unchanged. A long pseudo-random run over nine pages then compares every cycle against a recency-list model.

// File: rtl/xl_pkg.sv
package xl_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_ALTRD = 2'd3
    } acc_kind_e;

    localparam int unsigned DEF_VPN_W = 8;
    localparam int unsigned DEF_PPN_W = 28;
    localparam int unsigned DEF_OFF_W = 12;
    localparam int unsigned DEF_TLB_N = 4;
endpackage

// File: rtl/xl_match.sv
module xl_match #(
    parameter int unsigned N     = 4,
    parameter int unsigned VPN_W = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [N-1:0]            valid,
    input  logic [VPN_W-1:0]        vpn,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == vpn);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xl_lru.sv
module xl_lru #(
    parameter int unsigned N = 4,
    localparam int unsigned AGE_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [AGE_W-1:0] touch_idx,
    output logic [AGE_W-1:0] victim_idx
);
    logic [N-1:0][AGE_W-1:0] ages_d, ages_q;
    logic [N-1:0]            oldest;

    for (genvar g = 0; g < N; g++) begin : g_old
        assign oldest[g] = (ages_q[g] == AGE_W'(N - 1));
    end

    always_comb begin
        ages_d     = ages_q;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (oldest[i]) victim_idx = AGE_W'(i);
        end
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (AGE_W'(i) == touch_idx) begin
                    ages_d[i] = '0;
                end else if (ages_q[i] < ages_q[touch_idx]) begin
                    ages_d[i] = ages_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ages_q[i] <= AGE_W'(i);
        end else begin
            ages_q <= ages_d;
        end
    end

    p_single_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest));
    p_touch_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> ages_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/xl_ptab.sv
module xl_ptab #(
    parameter int unsigned VPN_W = 8,
    parameter int unsigned PPN_W = 28,
    localparam int unsigned DEPTH = 1 << VPN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [VPN_W-1:0] ld_idx,
    input  logic             ld_res,
    input  logic             ld_dirty,
    input  logic [PPN_W-1:0] ld_ppn,
    input  logic             wb_en,
    input  logic [VPN_W-1:0] wb_idx,
    input  logic [VPN_W-1:0] rd_idx,
    output logic             rd_res,
    output logic             rd_dirty,
    output logic [PPN_W-1:0] rd_ppn
);
    logic             res_d   [DEPTH];
    logic             res_q   [DEPTH];
    logic             dirty_d [DEPTH];
    logic             dirty_q [DEPTH];
    logic [PPN_W-1:0] ppn_d   [DEPTH];
    logic [PPN_W-1:0] ppn_q   [DEPTH];

    always_comb begin
        res_d   = res_q;
        dirty_d = dirty_q;
        ppn_d   = ppn_q;
        if (wb_en) dirty_d[wb_idx] = 1'b1;
        if (ld_en) begin
            res_d[ld_idx]   = ld_res;
            dirty_d[ld_idx] = ld_dirty;
            ppn_d[ld_idx]   = ld_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                res_q[i]   <= 1'b0;
                dirty_q[i] <= 1'b0;
                ppn_q[i]   <= '0;
            end
        end else begin
            res_q   <= res_d;
            dirty_q <= dirty_d;
            ppn_q   <= ppn_d;
        end
    end

    assign rd_res   = res_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_ppn   = ppn_q[rd_idx];

    p_wb_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(ld_en && ld_idx == wb_idx)) |=> dirty_q[$past(wb_idx)]);
    p_load_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (res_q[$past(ld_idx)] == $past(ld_res)) && (ppn_q[$past(ld_idx)] == $past(ld_ppn)));
endmodule

// File: rtl/xl_tlb.sv
module xl_tlb #(
    parameter int unsigned VPN_W = xl_pkg::DEF_VPN_W,
    parameter int unsigned PPN_W = xl_pkg::DEF_PPN_W,
    parameter int unsigned OFF_W = xl_pkg::DEF_OFF_W,
    parameter int unsigned TLB_N = xl_pkg::DEF_TLB_N,
    localparam int unsigned VA_W  = VPN_W + OFF_W,
    localparam int unsigned PA_W  = PPN_W + OFF_W,
    localparam int unsigned IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_miss,
    output logic             resp_fault,
    output logic             resp_dirty,
    input  logic             pt_ld_en,
    input  logic [VPN_W-1:0] pt_ld_vpn,
    input  logic             pt_ld_resident,
    input  logic             pt_ld_dirty,
    input  logic [PPN_W-1:0] pt_ld_ppn
);
    import xl_pkg::*;

    typedef struct packed {
        logic                        busy;
        logic [VPN_W-1:0]            pend_vpn;
        logic [OFF_W-1:0]            pend_off;
        logic                        pend_wr;
        logic [TLB_N-1:0][VPN_W-1:0] tags;
        logic [TLB_N-1:0]            valid;
        logic [TLB_N-1:0]            dirty;
        logic [TLB_N-1:0][PPN_W-1:0] ppns;
        logic                        rvalid;
        logic [PA_W-1:0]             rpaddr;
        logic                        rmiss;
        logic                        rfault;
        logic                        rdirty;
    } state_t;

    state_t s_d, s_q;

    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic [IDX_W-1:0] victim;
    logic             wb_en;
    logic [VPN_W-1:0] wb_idx;
    logic             pt_res;
    logic             pt_dirty;
    logic [PPN_W-1:0] pt_ppn;
    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             accept;
    logic             req_wr;
    logic             new_dirty;

    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign req_ready = !s_q.busy;
    assign accept    = req_valid && !s_q.busy;
    assign req_wr    = (req_kind == ACC_WRITE);

    xl_match #(.N(TLB_N), .VPN_W(VPN_W)) u_match (
        .tags  (s_q.tags),
        .valid (s_q.valid),
        .vpn   (req_vpn),
        .hit   (lk_hit),
        .idx   (lk_idx)
    );

    xl_lru #(.N(TLB_N)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim)
    );

    xl_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ptab (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (pt_ld_en),
        .ld_idx   (pt_ld_vpn),
        .ld_res   (pt_ld_resident),
        .ld_dirty (pt_ld_dirty),
        .ld_ppn   (pt_ld_ppn),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx),
        .rd_idx   (s_q.pend_vpn),
        .rd_res   (pt_res),
        .rd_dirty (pt_dirty),
        .rd_ppn   (pt_ppn)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.rpaddr = '0;
        s_d.rmiss  = 1'b0;
        s_d.rfault = 1'b0;
        s_d.rdirty = 1'b0;
        touch_en   = 1'b0;
        touch_idx  = '0;
        wb_en      = 1'b0;
        wb_idx     = '0;
        new_dirty  = 1'b0;

        if (s_q.busy) begin
            s_d.busy   = 1'b0;
            s_d.rvalid = 1'b1;
            s_d.rmiss  = 1'b1;
            if (!pt_res) begin
                s_d.rfault = 1'b1;
            end else begin
                if (s_q.valid[victim] && s_q.dirty[victim]) begin
                    wb_en  = 1'b1;
                    wb_idx = s_q.tags[victim];
                end
                new_dirty          = pt_dirty | s_q.pend_wr;
                s_d.tags[victim]   = s_q.pend_vpn;
                s_d.valid[victim]  = 1'b1;
                s_d.dirty[victim]  = new_dirty;
                s_d.ppns[victim]   = pt_ppn;
                s_d.rpaddr         = {pt_ppn, s_q.pend_off};
                s_d.rdirty         = new_dirty;
                touch_en           = 1'b1;
                touch_idx          = victim;
            end
        end else if (accept) begin
            if (lk_hit) begin
                new_dirty         = s_q.dirty[lk_idx] | req_wr;
                s_d.dirty[lk_idx] = new_dirty;
                s_d.rvalid        = 1'b1;
                s_d.rpaddr        = {s_q.ppns[lk_idx], req_off};
                s_d.rdirty        = new_dirty;
                touch_en          = 1'b1;
                touch_idx         = lk_idx;
            end else begin
                s_d.busy     = 1'b1;
                s_d.pend_vpn = req_vpn;
                s_d.pend_off = req_off;
                s_d.pend_wr  = req_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign resp_valid = s_q.rvalid;
    assign resp_paddr = s_q.rpaddr;
    assign resp_miss  = s_q.rmiss;
    assign resp_fault = s_q.rfault;
    assign resp_dirty = s_q.rdirty;

    p_hit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (resp_valid && !resp_miss && !resp_fault));
    p_miss_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lk_hit) |=> (!req_ready && !resp_valid) ##1 (resp_valid && resp_miss));
    p_fault_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_paddr == '0) && resp_miss && !resp_dirty);
    p_fault_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> $stable(s_q.tags) && $stable(s_q.valid) && $stable(s_q.dirty));
    p_offset_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> resp_paddr[OFF_W-1:0] == $past(req_off));
    p_write_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit && req_wr) |=> resp_dirty);
endmodule

// File: tb/tb_xl_tlb.sv
module tb_xl_tlb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [39:0] resp_paddr;
    logic        resp_miss, resp_fault, resp_dirty;
    logic        pt_ld_en = 1'b0;
    logic [7:0]  pt_ld_vpn = '0;
    logic        pt_ld_resident = 1'b0;
    logic        pt_ld_dirty = 1'b0;
    logic [27:0] pt_ld_ppn = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    bit          m_pres   [256];
    bit          m_pdirty [256];
    logic [27:0] m_pppn   [256];
    bit          c_valid  [4];
    int          c_tag    [4];
    bit          c_dirty  [4];
    logic [27:0] c_ppn    [4];
    int          order[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xl_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_miss(resp_miss),
        .resp_fault(resp_fault), .resp_dirty(resp_dirty),
        .pt_ld_en(pt_ld_en), .pt_ld_vpn(pt_ld_vpn), .pt_ld_resident(pt_ld_resident),
        .pt_ld_dirty(pt_ld_dirty), .pt_ld_ppn(pt_ld_ppn)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] ppn_of(input int v);
        return 28'((v * 32'h0013_579B) + 32'h00AB_CDE0);
    endfunction

    function automatic void touch(input int s);
        for (int i = 0; i < order.size(); i++) begin
            if (order[i] == s) begin
                order.delete(i);
                break;
            end
        end
        order.push_front(s);
    endfunction

    task automatic pt_load(input int v, input bit res, input bit dty, input logic [27:0] p);
        pt_ld_en = 1'b1; pt_ld_vpn = 8'(v);
        pt_ld_resident = res; pt_ld_dirty = dty; pt_ld_ppn = p;
        @(negedge clk);
        pt_ld_en = 1'b0;
        m_pres[v] = res; m_pdirty[v] = dty; m_pppn[v] = p;
        chk("R10 idle resp_valid", 64'(resp_valid), 64'd0);
    endtask

    task automatic access(input int v, input int off, input int kind);
        int          slot = -1;
        bit          wr = (kind == 2);
        bit          e_miss, e_fault, e_dirty;
        logic [39:0] e_pa;
        for (int s = 0; s < 4; s++) begin
            if (c_valid[s] && c_tag[s] == v) slot = s;
        end
        if (slot >= 0) begin
            e_miss = 0; e_fault = 0;
            c_dirty[slot] = c_dirty[slot] | wr;
            e_dirty = c_dirty[slot];
            e_pa = {c_ppn[slot], 12'(off)};
            touch(slot);
        end else begin
            e_miss = 1;
            if (!m_pres[v]) begin
                e_fault = 1; e_dirty = 0; e_pa = '0;
            end else begin
                int vic = order[order.size()-1];
                e_fault = 0;
                if (c_valid[vic] && c_dirty[vic]) m_pdirty[c_tag[vic]] = 1;
                e_dirty = m_pdirty[v] | wr;
                c_valid[vic] = 1; c_tag[vic] = v; c_dirty[vic] = e_dirty; c_ppn[vic] = m_pppn[v];
                e_pa = {m_pppn[v], 12'(off)};
                touch(vic);
            end
        end
        chk("R4 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_vaddr = {8'(v), 12'(off)}; req_kind = 2'(kind);
        @(negedge clk);
        req_valid = 1'b0;
        if (e_miss) begin
            chk("R4 no response during walk", 64'(resp_valid), 64'd0);
            chk("R4 ready low during walk", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        chk("R3/R4 resp_valid", 64'(resp_valid), 64'd1);
        chk("R3/R4 resp_miss", 64'(resp_miss), 64'(e_miss));
        chk("R6 resp_fault", 64'(resp_fault), 64'(e_fault));
        chk("R1 resp_paddr", 64'(resp_paddr), 64'(e_pa));
        chk("R2 resp_dirty", 64'(resp_dirty), 64'(e_dirty));
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int seed = 32'h1234_5678;
        for (int i = 0; i < 256; i++) begin
            m_pres[i] = 0; m_pdirty[i] = 0; m_pppn[i] = '0;
        end
        for (int s = 0; s < 4; s++) begin
            c_valid[s] = 0; c_tag[s] = 0; c_dirty[s] = 0; c_ppn[s] = '0;
            order.push_back(s);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 ready after reset", 64'(req_ready), 64'd1);
        chk("R10 no response after reset", 64'(resp_valid), 64'd0);
        access(8'h33, 12'h010, 1); // R10: empty table faults

        for (int v = 1; v <= 9; v++) pt_load(v, v != 5, v == 9, ppn_of(v));
        pt_load(8'hFF, 1, 0, 28'hFFF_FFFF);

        // R4 miss then R3 hits with several kinds, R1 offset extremes
        access(1, 12'hFF8, 1);
        access(1, 12'hFFC, 0);
        access(1, 12'h000, 3);       // R2 code 3 behaves as read
        access(1, 12'h123, 2);       // R2 write hit sets dirty
        access(8'hFF, 12'hFFF, 0);   // R1 all-ones page and offset
        // R6 fault leaves cache and recency untouched
        access(5, 12'h040, 2);
        access(1, 12'h004, 1);
        // R5/R7: age page 1 out with four refills, then reread it
        access(2, 12'h100, 0);
        access(3, 12'h200, 1);
        access(4, 12'h300, 0);
        access(6, 12'h400, 1);
        access(1, 12'h008, 1);       // R7 write-back visible as dirty
        // R8 refill of a write, and of a page loaded dirty
        access(7, 12'h500, 2);
        access(9, 12'h600, 0);
        // R2 fetch on clean page stays clean
        access(3, 12'h700, 0);
        // R9 reload of a cached page keeps the stale translation
        pt_load(3, 1, 0, 28'h0C0_FFEE);
        access(3, 12'h710, 1);
        // R5 recency: touch 7 then refill twice, 7 must survive
        access(7, 12'h020, 1);
        access(2, 12'h030, 1);
        access(4, 12'h040, 1);
        access(7, 12'h050, 1);

        for (int n = 0; n < 400; n++) begin
            seed = seed * 1103515245 + 12345;
            access(1 + ((seed >>> 16) & 32'h7FFF) % 9, (seed >>> 4) & 12'hFFF,
                   ((seed >>> 24) & 32'hFF) % 4);
            if (n % 97 == 50) begin
                seed = seed * 1103515245 + 12345;
                pt_load(1 + ((seed >>> 16) & 32'h7FFF) % 9, 1, 0, 28'(seed)); // R9
            end
            if (n % 5 == 0) begin
                @(negedge clk);
                chk("R3 no spurious response", 64'(resp_valid), 64'd0);
            end
        end
        done = 1'b1;
        report();
    end
endmodule